// File: doc/BRIEF.md
# Serial-Core Instruction Fetch Capture

This block runs the fetch handshake at the front of a bit-serial processor core. A single-cycle start pulse opens a bus cycle on a simple instruction bus, and the request stays up until memory answers with an acknowledge. In the acknowledge cycle the block ends the bus cycle. It also stores the instruction fields that later stages read: the major opcode, the 3-bit function field, instruction bit 30, both register-address groups and the raw immediate bits.

In that same acknowledge cycle it sends a one-cycle read request to the register file, so that operand streaming can start at once. At capture time it also sorts the instruction into the two-stage or one-stage class. Two-stage covers jumps, branches, loads, stores, shifts and set-less-than. It also marks the subset of two-stage instructions that may later raise an exception. Full control decode and program-counter update belong to other blocks.

Top module: `fetch_capture`

## Requirements
- R1: While rst_n is low and in the first cycle after it is released, bus_cyc, rf_read_req, two_stage and may_except are 0, one_stage is 1, and every captured field is 0.
- R2: A fetch_start pulse while bus_cyc is low makes bus_cyc high from the next cycle. bus_cyc then stays high for as long as bus_ack is low.
- R3: When bus_ack is high while bus_cyc is high, bus_cyc is low from the next cycle.
- R4: rf_read_req is high in exactly the cycle where bus_ack and bus_cyc are both high, and it lasts one cycle. An acknowledge while bus_cyc is low gives no strobe and changes no captured field.
- R5: From the cycle after an accepted acknowledge: op_code equals bus_rdata[6:2], fn3 equals bus_rdata[14:12], and bit30 equals bus_rdata[30].
- R6: From the cycle after an accepted acknowledge: rs_field equals bus_rdata[24:15], rd_field equals bus_rdata[11:7], and imm_bits equals bus_rdata[31:7].
- R7: two_stage is 1 and one_stage is 0 when the captured opcode is one of the following: jump 11011 or 11001, branch 11000, load 00000, store 01000, or ALU 00100 or 01100 with fn3 equal to 001, 101, 010 or 011. Any other opcode gives two_stage 0 and one_stage 1.
- R8: may_except is 1 only for jump, branch, load and store opcodes. It is 0 for every other opcode, including shifts and set-less-than.
- R9: Captured fields and class flags keep their values until the next accepted acknowledge.
- R10: A fetch_start pulse while bus_cyc is already high has no effect: bus_cyc stays high, and a single acknowledge ends the cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_start | input | 1 | Pulse that starts a fetch |
| bus_ack | input | 1 | Memory acknowledge |
| bus_rdata | input | 32 | Instruction word from memory |
| bus_cyc | output | 1 | Bus cycle request |
| op_code | output | 5 | Captured opcode bits [6:2] |
| fn3 | output | 3 | Captured bits [14:12] |
| bit30 | output | 1 | Captured bit 30 |
| rs_field | output | 10 | Captured source register bits [24:15] |
| rd_field | output | 5 | Captured destination bits [11:7] |
| imm_bits | output | 25 | Captured immediate bits [31:7] |
| rf_read_req | output | 1 | One-cycle register-file read request |
| two_stage | output | 1 | Instruction needs two stages |
| one_stage | output | 1 | Instruction completes in one stage |
| may_except | output | 1 | Instruction may raise an exception |

## Verification
The hardest cases to reach are the acknowledges that must be rejected. One is a stray acknowledge while no cycle is open. The other is a second start pulse while a cycle is still outstanding. The bench first captures a known word, then drives an acknowledge with a different word while idle, and confirms there is no strobe and that every field keeps its old value. In a separate case it pulses the start input again partway through a held cycle, and then confirms that one acknowledge closes the cycle for good.

// File: rtl/fetch_capture.sv
module fetch_capture #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_start,
  input  logic            bus_ack,
  input  logic [XLEN-1:0] bus_rdata,
  output logic            bus_cyc,
  output logic [4:0]      op_code,
  output logic [2:0]      fn3,
  output logic            bit30,
  output logic [9:0]      rs_field,
  output logic [4:0]      rd_field,
  output logic [24:0]     imm_bits,
  output logic            rf_read_req,
  output logic            two_stage,
  output logic            one_stage,
  output logic            may_except
);

  logic       take;
  logic [4:0] nop;
  logic [2:0] nf3;
  logic       is_jmp, is_mem, is_alu, is_sh, is_slt;

  assign take        = bus_cyc & bus_ack;
  assign rf_read_req = take;
  assign one_stage   = ~two_stage;

  assign nop    = bus_rdata[6:2];
  assign nf3    = bus_rdata[14:12];
  assign is_jmp = (nop == 5'b11011) | (nop == 5'b11001) | (nop == 5'b11000);
  assign is_mem = (nop == 5'b00000) | (nop == 5'b01000);
  assign is_alu = (nop == 5'b00100) | (nop == 5'b01100);
  assign is_sh  = is_alu & (nf3[1:0] == 2'b01);
  assign is_slt = is_alu & (nf3[2:1] == 2'b01);

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_cyc <= 1'b0;
    else if (take)
      bus_cyc <= 1'b0;
    else if (fetch_start)
      bus_cyc <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_code    <= '0;
      fn3        <= '0;
      bit30      <= 1'b0;
      rs_field   <= '0;
      rd_field   <= '0;
      imm_bits   <= '0;
      two_stage  <= 1'b0;
      may_except <= 1'b0;
    end else if (take) begin
      op_code    <= nop;
      fn3        <= nf3;
      bit30      <= bus_rdata[30];
      rs_field   <= bus_rdata[24:15];
      rd_field   <= bus_rdata[11:7];
      imm_bits   <= bus_rdata[31:7];
      two_stage  <= is_jmp | is_mem | is_sh | is_slt;
      may_except <= is_jmp | is_mem;
    end
  end

endmodule

module fetch_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fetch_start,
  input logic        bus_ack,
  input logic        bus_cyc,
  input logic        rf_read_req,
  input logic        two_stage,
  input logic        may_except,
  input logic [4:0]  op_code,
  input logic [24:0] imm_bits
);
  a_r2_cyc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && !bus_ack |=> bus_cyc);
  a_r3_cyc_ends: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && bus_ack |=> !bus_cyc);
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rf_read_req |=> !rf_read_req && !bus_cyc);
  a_r4_no_idle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cyc |-> !rf_read_req);
  a_r8_except_subset: assert property (@(posedge clk) disable iff (!rst_n)
    may_except |-> two_stage);
  a_r9_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_read_req |=> $stable(op_code) && $stable(imm_bits) && $stable(two_stage));
  a_r10_restart_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && fetch_start && !bus_ack |=> bus_cyc);
endmodule

bind fetch_capture fetch_capture_chk chk_i (
  .clk(clk), .rst_n(rst_n), .fetch_start(fetch_start), .bus_ack(bus_ack),
  .bus_cyc(bus_cyc), .rf_read_req(rf_read_req), .two_stage(two_stage),
  .may_except(may_except), .op_code(op_code), .imm_bits(imm_bits)
);

// File: tb/fetch_capture_tb_top.sv
module fetch_capture_tb_top;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0, fetch_start = 0, bus_ack = 0;
  logic [31:0] bus_rdata = '0;
  logic        bus_cyc, bit30, rf_read_req, two_stage, one_stage, may_except;
  logic [4:0]  op_code, rd_field;
  logic [2:0]  fn3;
  logic [9:0]  rs_field;
  logic [24:0] imm_bits;
  int n_chk = 0, n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  fetch_capture dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [4:0] op, logic [2:0] f3, logic [31:0] up);
    return (up & ~32'h0000_707F) | (32'(f3) << 12) | (32'(op) << 2) | 32'h3;
  endfunction

  task automatic do_fetch(logic [31:0] w, int wait_n, logic ts, logic ex);
    fetch_start = 1;
    @(negedge clk); fetch_start = 0;
    chk("R2 cyc raised", 32'(bus_cyc), 1);
    for (int i = 0; i < wait_n; i++) begin
      @(negedge clk);
      chk("R2 cyc held", 32'(bus_cyc), 1);
      chk("R4 no early strobe", 32'(rf_read_req), 0);
    end
    bus_ack = 1; bus_rdata = w; #1;
    chk("R4 strobe with ack", 32'(rf_read_req), 1);
    @(negedge clk); bus_ack = 0; bus_rdata = ~w; #1;
    chk("R3 cyc dropped", 32'(bus_cyc), 0);
    chk("R4 strobe one cycle", 32'(rf_read_req), 0);
    chk("R5 opcode", 32'(op_code), 32'(w[6:2]));
    chk("R5 funct", 32'(fn3), 32'(w[14:12]));
    chk("R5 bit30", 32'(bit30), 32'(w[30]));
    chk("R6 rs", 32'(rs_field), 32'(w[24:15]));
    chk("R6 rd", 32'(rd_field), 32'(w[11:7]));
    chk("R6 imm", 32'(imm_bits), 32'(w[31:7]));
    chk("R7 two", 32'(two_stage), 32'(ts));
    chk("R7 one", 32'(one_stage), 32'(!ts));
    chk("R8 except", 32'(may_except), 32'(ex));
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk); @(negedge clk);
    chk("R1 cyc", 32'(bus_cyc), 0);
    chk("R1 rreq", 32'(rf_read_req), 0);
    chk("R1 imm", 32'(imm_bits), 0);
    chk("R1 flags", {29'd0, two_stage, one_stage, may_except}, 32'b010);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {29'd0, bus_cyc, one_stage, two_stage}, 32'b010);
  endtask

  task automatic t_stray_ack();
    logic [31:0] w = mk(5'b00000, 3'b010, 32'h1234_5678);
    do_fetch(w, 1, 1, 1);
    bus_ack = 1; bus_rdata = mk(5'b01101, 3'b000, 32'hFFFF_FFFF); #1;
    chk("R4 idle ack no strobe", 32'(rf_read_req), 0);
    @(negedge clk); bus_ack = 0;
    chk("R4 idle ack cyc", 32'(bus_cyc), 0);
    chk("R9 opcode kept", 32'(op_code), 32'(w[6:2]));
    chk("R9 imm kept", 32'(imm_bits), 32'(w[31:7]));
    chk("R9 class kept", {30'd0, two_stage, may_except}, 32'b11);
  endtask

  task automatic t_restart();
    fetch_start = 1;
    @(negedge clk);
    @(negedge clk); fetch_start = 0;
    chk("R10 cyc still high", 32'(bus_cyc), 1);
    fetch_start = 1;
    @(negedge clk); fetch_start = 0;
    chk("R10 repeat pulse", 32'(bus_cyc), 1);
    bus_ack = 1; bus_rdata = mk(5'b01100, 3'b000, 32'h0); #1;
    chk("R4 strobe after restart", 32'(rf_read_req), 1);
    @(negedge clk); bus_ack = 0;
    chk("R10 one ack ends", 32'(bus_cyc), 0);
    @(negedge clk);
    chk("R10 stays idle", 32'(bus_cyc), 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    do_fetch(mk(5'b01100, 3'b000, 32'h4ABC_DEF0), 0, 0, 0);
    do_fetch(mk(5'b01100, 3'b001, 32'h0123_4567), 3, 1, 0);
    do_fetch(mk(5'b00100, 3'b101, 32'hBEEF_0000), 1, 1, 0);
    do_fetch(mk(5'b00100, 3'b010, 32'h8000_1F80), 2, 1, 0);
    do_fetch(mk(5'b01100, 3'b011, 32'h3333_3333), 0, 1, 0);
    do_fetch(mk(5'b00100, 3'b110, 32'h7777_7777), 1, 0, 0);
    do_fetch(mk(5'b01000, 3'b010, 32'hC0DE_CAFE), 1, 1, 1);
    do_fetch(mk(5'b11011, 3'b000, 32'hFFFF_FFFF), 4, 1, 1);
    do_fetch(mk(5'b11001, 3'b000, 32'h0F0F_0F0F), 0, 1, 1);
    do_fetch(mk(5'b11000, 3'b100, 32'hA5A5_A5A5), 2, 1, 1);
    do_fetch(mk(5'b01101, 3'b000, 32'h5555_5555), 1, 0, 0);
    t_stray_ack();
    t_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule